// File: doc/BRIEF.md
# Descriptor-Walking Storage DMA Engine

This block is a bus-master DMA engine for a single serial storage port. Software places a table of 8-byte descriptors in memory. Each descriptor gives the start address of a data buffer and its length. Software then loads the table base, picks a direction and sets Start. The engine reads each descriptor over a one-word memory request interface. It then moves the buffer word by word, either from memory into the port's transmit FIFO or from the port's receive FIFO into memory. When the final descriptor is used up, it raises an interrupt.

Two pulse inputs report the first Activate frame and the first Data frame from the device. A mode input chooses when the first descriptor read may begin. In legacy mode it waits for the frame that matches the direction. In direct mode it begins at once when Start is set. In either mode, data words move only after the matching frame has been seen. A software-reset pulse halts a transfer in progress. A fatal abort from memory halts it and sets Error. Requests answered with retry or disconnect are issued again until they complete.

Top module: `stor_dma_engine`

## Requirements
- R1: A descriptor is two words at the table pointer: +0 holds the buffer address (bits 1:0 ignored) and +4 holds the length, whose bits 15:2 are a word count (zero meaning 16384 words, bits 1:0 ignored) and whose bit 31 flags the final descriptor; the next descriptor is read 8 bytes further on.
- R2: Register map read on reg_rdata for reg_addr: 0 command (bit 0 Start, bit 3 direction, 1 = device to memory), 1 status (bit 0 Active, bit 1 Error, bit 2 Interrupt), 2 table pointer (bits 1:0 read as zero), 3 reads zero; direction and pointer writes are ignored while Active is set.
- R3: A command write that takes Start from 0 to 1 while Active is clear sets Active on that edge; a write of Start=1 when Start already reads 1 starts nothing, and no memory request is made while Active is clear.
- R4: In legacy mode (mode_direct=0) the first descriptor read waits for ev_activate when moving memory to device and for ev_data when moving device to memory; the other event does not start it.
- R5: In direct mode the first descriptor read is presented in the cycle after the edge that sets Active, with no device event.
- R6: In both modes no data-word request is made until the direction's event (ev_activate for memory to device, ev_data for device to memory) has been seen since Start.
- R7: A memory write of device data is issued only while rx_level is at least THRESH words, or the current descriptor is the final one and rx_level covers all its remaining words.
- R8: Response codes are 0 done, 1 retry, 2 disconnect, 3 abort; after a retry or disconnect the same request (address and write flag) is presented again in the next cycle.
- R9: On the edge of the done response for the last word of the final descriptor, Active clears and Interrupt sets; irq follows Interrupt.
- R10: Error and Interrupt clear when a status write has a 1 in their bit; a 0 leaves them alone, Active is not writable, and a set on the same edge wins over a clear.
- R11: An abort response sets Error, clears Active without setting Interrupt, and no further request follows.
- R12: A soft_rst pulse while Active is set clears Active on that edge without setting Interrupt, and requests stop.
- R13: A memory-to-device word is pushed to tx_data with tx_push in the cycle of its done response, and a read is not started while tx_full is high; a device-to-memory write carries rx_data and pulses rx_pop in the cycle of its done response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mode_direct | input | 1 | 1 = fetch on Start, 0 = fetch on device event |
| ev_activate | input | 1 | Pulse: Activate frame seen from device |
| ev_data | input | 1 | Pulse: Data frame seen from device |
| soft_rst | input | 1 | Pulse: software reset of the port |
| mreq_valid | output | 1 | Memory request present |
| mreq_write | output | 1 | 1 = write, 0 = read |
| mreq_addr | output | 32 | Request word address |
| mreq_wdata | output | 32 | Write data |
| mrsp_valid | input | 1 | Response present this cycle |
| mrsp_code | input | 2 | 0 done, 1 retry, 2 disconnect, 3 abort |
| mrsp_rdata | input | 32 | Read data with a done response |
| tx_push | output | 1 | Push a word into the transmit FIFO |
| tx_data | output | 32 | Word pushed |
| tx_full | input | 1 | Transmit FIFO cannot accept |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| rx_data | input | 32 | Head word of the receive FIFO |
| rx_pop | output | 1 | Remove the head word |
| irq | output | 1 | Interrupt status bit |

## Verification
Each result has a fixed cycle. A register write or event shows on reg_rdata and on the request outputs in the cycle after the rising edge that takes it. The first descriptor read in direct mode appears one cycle after Start. tx_push, rx_pop and the Active and Interrupt change all land on the edge that takes a done response. Retries show the same request again one cycle later. The bench drives inputs just after the falling edge. Its behavioural model predicts every output for that cycle, and the bench compares 3 ns after the falling edge, before the next rising edge, on every clock. It then steps the model with the same inputs that the design sees at that rising edge.

// File: rtl/stor_dma_engine.sv
module stor_dma_engine #(
  parameter int THRESH = 4,
  parameter int LVL_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             mode_direct,
  input  logic             ev_activate,
  input  logic             ev_data,
  input  logic             soft_rst,
  output logic             mreq_valid,
  output logic             mreq_write,
  output logic [31:0]      mreq_addr,
  output logic [31:0]      mreq_wdata,
  input  logic             mrsp_valid,
  input  logic [1:0]       mrsp_code,
  input  logic [31:0]      mrsp_rdata,
  output logic             tx_push,
  output logic [31:0]      tx_data,
  input  logic             tx_full,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [31:0]      rx_data,
  output logic             rx_pop,
  output logic             irq
);

  localparam int CW = 15;
  localparam logic [CW-1:0] MAXW = CW'(16384);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_FADR, S_FCNT, S_WAIT, S_MOVE} st_t;
  st_t st;

  logic          start, dir, active, err, intr, seen_a, seen_d, last;
  logic [31:0]   tbl, cur, bufa;
  logic [CW-1:0] left;

  wire go    = dir ? (seen_d | ev_data) : (seen_a | ev_activate);
  wire ok    = mrsp_valid && mrsp_code == 2'd0;
  wire abort = mrsp_valid && mrsp_code == 2'd3;
  wire kick  = reg_we && reg_addr == 2'd0 && reg_wdata[0] && !start && !active;
  wire rx_ok = (32'(rx_level) >= 32'(THRESH)) || (last && 32'(rx_level) >= 32'(left));
  wire ready = dir ? rx_ok : !tx_full;
  wire [CW-1:0] words = (mrsp_rdata[15:2] == 14'd0) ? MAXW : {1'b0, mrsp_rdata[15:2]};

  assign mreq_valid = st == S_FADR || st == S_FCNT || st == S_MOVE;
  assign mreq_write = st == S_MOVE && dir;
  assign mreq_addr  = st == S_FADR ? cur : st == S_FCNT ? cur + 32'd4 : bufa;
  assign mreq_wdata = rx_data;
  assign tx_push    = st == S_MOVE && !dir && ok;
  assign tx_data    = mrsp_rdata;
  assign rx_pop     = st == S_MOVE && dir && ok;
  assign irq        = intr;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, dir, 2'b00, start};
      2'd1:    reg_rdata = {29'd0, intr, err, active};
      2'd2:    reg_rdata = tbl;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {start, dir, active, err, intr, seen_a, seen_d, last} <= '0;
      tbl  <= '0;
      cur  <= '0;
      bufa <= '0;
      left <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            start <= reg_wdata[0];
            if (!active) dir <= reg_wdata[3];
          end
          2'd1: begin
            if (reg_wdata[1]) err  <= 1'b0;
            if (reg_wdata[2]) intr <= 1'b0;
          end
          2'd2: if (!active) tbl <= {reg_wdata[31:2], 2'b00};
          default: ;
        endcase
      end
      if (active) begin
        seen_a <= seen_a | ev_activate;
        seen_d <= seen_d | ev_data;
      end
      if (kick) begin
        active <= 1'b1;
        seen_a <= 1'b0;
        seen_d <= 1'b0;
        cur    <= tbl;
        st     <= mode_direct ? S_FADR : S_ARM;
      end else if (soft_rst && active) begin
        active <= 1'b0;
        st     <= S_IDLE;
      end else if (mreq_valid && abort) begin
        err    <= 1'b1;
        active <= 1'b0;
        st     <= S_IDLE;
      end else begin
        case (st)
          S_ARM:  if (go) st <= S_FADR;
          S_FADR: if (ok) begin
            bufa <= {mrsp_rdata[31:2], 2'b00};
            st   <= S_FCNT;
          end
          S_FCNT: if (ok) begin
            left <= words;
            last <= mrsp_rdata[31];
            st   <= S_WAIT;
          end
          S_WAIT: if (go && ready) st <= S_MOVE;
          S_MOVE: if (ok) begin
            bufa <= bufa + 32'd4;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              if (last) begin
                active <= 1'b0;
                intr   <= 1'b1;
                st     <= S_IDLE;
              end else begin
                cur <= cur + 32'd8;
                st  <= S_FADR;
              end
            end else begin
              st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mrsp_valid && (mrsp_code == 2'd1 || mrsp_code == 2'd2) && !soft_rst
    |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_write));

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mrsp_valid && mrsp_code == 2'd3 && !soft_rst |=> !mreq_valid && err);

  // R7
  wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_write |-> rx_level != '0);

  // R12
  srst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && active |=> !active && !mreq_valid);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mreq_valid);

  // R9
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(active));

endmodule

// File: tb/tb_stor_dma_engine.sv
module tb_stor_dma_engine;
  localparam int THRESH = 4;
  localparam int LVL_W  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_we, mode_direct, ev_activate, ev_data, soft_rst;
  logic [1:0]  reg_addr, mrsp_code;
  logic [31:0] reg_wdata, reg_rdata, mreq_addr, mreq_wdata, mrsp_rdata, tx_data, rx_data;
  logic mreq_valid, mreq_write, mrsp_valid, tx_push, tx_full, rx_pop, irq;
  logic [LVL_W-1:0] rx_level;

  int rx_lvl, rx_idx;
  assign rx_level = LVL_W'(rx_lvl);
  assign rx_data  = 32'hD000_0000 + 32'(rx_idx);

  stor_dma_engine #(.THRESH(THRESH), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mode_direct(mode_direct), .ev_activate(ev_activate), .ev_data(ev_data),
    .soft_rst(soft_rst), .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_addr(mreq_addr),
    .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid), .mrsp_code(mrsp_code), .mrsp_rdata(mrsp_rdata),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .rx_level(rx_level), .rx_data(rx_data),
    .rx_pop(rx_pop), .irq(irq));

  int checks = 0, errors = 0;
  logic [31:0] mem [int unsigned];
  int pat = 0, att = 0;
  logic [31:0] abort_addr = 32'hFFFF_FFFF;
  int npush, npop, nvalid, nretry;

  // reference model state
  int m_ph, m_left;
  bit m_start, m_dir, m_act, m_err, m_intr, m_sa, m_sd, m_last;
  logic [31:0] m_tbl, m_cur, m_buf;
  bit e_valid, e_write, e_push, e_pop;
  logic [31:0] e_addr;

  task automatic chk(bit c, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] m_rdata();
    case (reg_addr)
      2'd0: return {28'd0, m_dir, 3'b000} | 32'(m_start);
      2'd1: return 32'({m_intr, m_err, m_act});
      2'd2: return m_tbl;
      default: return 32'd0;
    endcase
  endfunction

  task automatic respond();
    mrsp_valid = 1'b0; mrsp_code = 2'd0; mrsp_rdata = 32'd0;
    if (mreq_valid) begin
      if (pat == 0) mrsp_valid = 1'b1;
      else begin
        case (att % 4)
          0: mrsp_valid = 1'b0;
          1: begin mrsp_valid = 1'b1; mrsp_code = 2'd1; end
          2: begin mrsp_valid = 1'b1; mrsp_code = 2'd2; end
          default: mrsp_valid = 1'b1;
        endcase
        att++;
      end
      if (mrsp_valid && !mreq_write && mreq_addr == abort_addr) mrsp_code = 2'd3;
      if (!mreq_write) mrsp_rdata = memrd(mreq_addr);
    end
  endtask

  task automatic compare();
    e_valid = m_ph == 2 || m_ph == 3 || m_ph == 5;
    e_write = m_ph == 5 && m_dir;
    e_addr  = m_ph == 2 ? m_cur : m_ph == 3 ? m_cur + 32'd4 : m_buf;
    e_push  = m_ph == 5 && !m_dir && mrsp_valid && mrsp_code == 2'd0;
    e_pop   = m_ph == 5 && m_dir && mrsp_valid && mrsp_code == 2'd0;
    chk(mreq_valid === e_valid, "R8", "mreq_valid", 64'(mreq_valid), 64'(e_valid));
    if (e_valid) begin
      chk(mreq_addr === e_addr, "R1", "mreq_addr", 64'(mreq_addr), 64'(e_addr));
      chk(mreq_write === e_write, "R2", "mreq_write", 64'(mreq_write), 64'(e_write));
    end
    if (e_valid && e_write)
      chk(mreq_wdata === rx_data, "R13", "mreq_wdata", 64'(mreq_wdata), 64'(rx_data));
    chk(tx_push === e_push, "R13", "tx_push", 64'(tx_push), 64'(e_push));
    if (e_push) chk(tx_data === mrsp_rdata, "R13", "tx_data", 64'(tx_data), 64'(mrsp_rdata));
    chk(rx_pop === e_pop, "R13", "rx_pop", 64'(rx_pop), 64'(e_pop));
    chk(irq === m_intr, "R9", "irq", 64'(irq), 64'(m_intr));
    chk(reg_rdata === m_rdata(), "R2", "reg_rdata", 64'(reg_rdata), 64'(m_rdata()));
  endtask

  task automatic model_step();
    bit o_act = m_act;
    bit o_start = m_start;
    bit go, ok, ab, kick, rdy;
    int w;
    go   = m_dir ? (m_sd || ev_data) : (m_sa || ev_activate);
    ok   = mrsp_valid && mrsp_code == 2'd0;
    ab   = mrsp_valid && mrsp_code == 2'd3;
    kick = reg_we && reg_addr == 2'd0 && reg_wdata[0] && !o_start && !o_act;
    rdy  = m_dir ? (rx_lvl >= THRESH || (m_last && rx_lvl >= m_left)) : !tx_full;
    if (reg_we) begin
      if (reg_addr == 2'd0) begin
        m_start = reg_wdata[0];
        if (!o_act) m_dir = reg_wdata[3];
      end else if (reg_addr == 2'd1) begin
        if (reg_wdata[1]) m_err = 1'b0;
        if (reg_wdata[2]) m_intr = 1'b0;
      end else if (reg_addr == 2'd2) begin
        if (!o_act) m_tbl = reg_wdata & 32'hFFFF_FFFC;
      end
    end
    if (o_act) begin
      m_sa = m_sa || ev_activate;
      m_sd = m_sd || ev_data;
    end
    if (kick) begin
      m_act = 1'b1; m_sa = 1'b0; m_sd = 1'b0; m_cur = m_tbl;
      m_ph = mode_direct ? 2 : 1;
    end else if (soft_rst && o_act) begin
      m_act = 1'b0; m_ph = 0;
    end else if (e_valid && ab) begin
      m_err = 1'b1; m_act = 1'b0; m_ph = 0;
    end else begin
      case (m_ph)
        1: if (go) m_ph = 2;
        2: if (ok) begin m_buf = mrsp_rdata & 32'hFFFF_FFFC; m_ph = 3; end
        3: if (ok) begin
          w = int'(mrsp_rdata[15:2]);
          if (w == 0) w = 16384;
          m_left = w; m_last = mrsp_rdata[31]; m_ph = 4;
        end
        4: if (go && rdy) m_ph = 5;
        5: if (ok) begin
          m_buf = m_buf + 32'd4;
          m_left--;
          if (m_left == 0) begin
            if (m_last) begin m_act = 1'b0; m_intr = 1'b1; m_ph = 0; end
            else begin m_cur = m_cur + 32'd8; m_ph = 2; end
          end else m_ph = 4;
        end
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    bit pop;
    #2;
    respond();
    #1;
    compare();
    if (mreq_valid) nvalid++;
    if (mrsp_valid && (mrsp_code == 2'd1 || mrsp_code == 2'd2)) nretry++;
    if (tx_push) npush++;
    if (rx_pop) npop++;
    pop = e_pop;
    model_step();
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; ev_activate = 1'b0; ev_data = 1'b0; soft_rst = 1'b0;
    if (pop) begin rx_lvl--; rx_idx++; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_addr = 2'd1;
  endtask

  task automatic run_to_idle(int lim);
    for (int i = 0; i < lim && m_act; i++) tick();
  endtask

  task automatic clr_counts();
    npush = 0; npop = 0; nvalid = 0; nretry = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end in time");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd1; reg_wdata = 32'd0;
    mode_direct = 1'b0; ev_activate = 1'b0; ev_data = 1'b0; soft_rst = 1'b0;
    mrsp_valid = 1'b0; mrsp_code = 2'd0; mrsp_rdata = 32'd0; tx_full = 1'b0;
    rx_lvl = 0; rx_idx = 0;
    m_ph = 0; m_left = 0; m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_intr = 0;
    m_sa = 0; m_sd = 0; m_last = 0; m_tbl = 0; m_cur = 0; m_buf = 0;
    mem[32'h100] = 32'h0000_1000; mem[32'h104] = 32'h0000_0008;
    mem[32'h108] = 32'h0000_2000; mem[32'h10C] = 32'h8000_000C;
    mem[32'h200] = 32'h0000_3000; mem[32'h204] = 32'h8000_0018;
    mem[32'h300] = 32'h0000_4000; mem[32'h304] = 32'h8000_0004;
    mem[32'h400] = 32'h0000_5000; mem[32'h404] = 32'h8000_0010;
    mem[32'h500] = 32'h0000_6000; mem[32'h504] = 32'h8000_0040;
    mem[32'h600] = 32'h0001_0000; mem[32'h604] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    #1;
    chk(reg_rdata === 32'd0, "R2", "status after reset", 64'(reg_rdata), 0);
    chk(mreq_valid === 1'b0 && irq === 1'b0, "R3", "quiet after reset", 64'({mreq_valid, irq}), 0);
    idle(2);

    // direct mode, memory to device, two descriptors
    mode_direct = 1'b1;
    wr(2'd2, 32'h0000_0103);
    reg_addr = 2'd2; #1;
    chk(reg_rdata === 32'h100, "R2", "pointer low bits", 64'(reg_rdata), 64'h100);
    reg_addr = 2'd1;
    clr_counts();
    wr(2'd0, 32'h1);
    #1;
    chk(mreq_valid === 1'b1 && mreq_addr === 32'h100, "R5", "fetch right after Start",
        64'({mreq_valid, mreq_addr}), 64'({1'b1, 32'h100}));
    chk(reg_rdata[0] === 1'b1, "R3", "Active after Start", 64'(reg_rdata), 1);
    idle(10);
    chk(npush == 0 && mreq_valid === 1'b0, "R6", "no data before Activate", 64'(npush), 0);
    ev_activate = 1'b1;
    tick();
    run_to_idle(200);
    chk(npush == 5, "R1", "words from two descriptors", 64'(npush), 5);
    chk(reg_rdata === 32'h4 && irq === 1'b1, "R9", "Interrupt on finish", 64'(reg_rdata), 4);
    wr(2'd0, 32'h1);
    idle(3);
    chk(reg_rdata[0] === 1'b0 && mreq_valid === 1'b0, "R3", "Start already set, no restart",
        64'(reg_rdata), 4);
    wr(2'd1, 32'h1);
    chk(reg_rdata === 32'h4, "R10", "write of 0 keeps Interrupt", 64'(reg_rdata), 4);
    wr(2'd1, 32'h4);
    chk(reg_rdata === 32'h0, "R10", "write 1 clears Interrupt", 64'(reg_rdata), 0);
    wr(2'd0, 32'h0);

    // legacy mode, device to memory, retries, threshold
    mode_direct = 1'b0; pat = 1; att = 0;
    wr(2'd2, 32'h200);
    clr_counts();
    wr(2'd0, 32'h9);
    reg_addr = 2'd0; #1;
    chk(reg_rdata === 32'h9, "R2", "command readback", 64'(reg_rdata), 9);
    reg_addr = 2'd1;
    idle(6);
    ev_activate = 1'b1;
    tick();
    idle(5);
    chk(nvalid == 0, "R4", "legacy fetch ignores Activate for device-to-memory", 64'(nvalid), 0);
    ev_data = 1'b1;
    tick();
    #1;
    chk(mreq_valid === 1'b1 && mreq_addr === 32'h200, "R4", "legacy fetch on Data",
        64'(mreq_addr), 64'h200);
    rx_lvl = 2;
    idle(30);
    chk(npop == 0, "R7", "no write below threshold", 64'(npop), 0);
    rx_lvl = 6;
    run_to_idle(400);
    chk(npop == 6, "R7", "final descriptor flushes below threshold", 64'(npop), 6);
    chk(nretry > 0, "R8", "retries seen and completed", 64'(nretry), 1);
    chk(reg_rdata === 32'h4, "R9", "status after device-to-memory", 64'(reg_rdata), 4);
    wr(2'd1, 32'h4);
    wr(2'd0, 32'h0);
    pat = 0;

    // legacy mode, memory to device, Data does not start, tx_full stalls
    wr(2'd2, 32'h300);
    clr_counts();
    wr(2'd0, 32'h1);
    ev_data = 1'b1;
    tick();
    idle(4);
    chk(nvalid == 0, "R4", "legacy fetch ignores Data for memory-to-device", 64'(nvalid), 0);
    tx_full = 1'b1;
    ev_activate = 1'b1;
    tick();
    idle(10);
    chk(npush == 0 && mreq_valid === 1'b0, "R13", "no read while tx_full", 64'(npush), 0);
    tx_full = 1'b0;
    run_to_idle(50);
    chk(npush == 1, "R13", "word pushed after tx_full drops", 64'(npush), 1);
    wr(2'd1, 32'h4);
    wr(2'd0, 32'h0);

    // abort
    mode_direct = 1'b1;
    abort_addr = 32'h5008;
    wr(2'd2, 32'h400);
    clr_counts();
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h999);
    reg_addr = 2'd2; #1;
    chk(reg_rdata === 32'h400, "R2", "pointer write ignored while Active", 64'(reg_rdata), 64'h400);
    reg_addr = 2'd1;
    ev_activate = 1'b1;
    tick();
    run_to_idle(100);
    chk(reg_rdata === 32'h2 && irq === 1'b0, "R11", "abort sets Error only", 64'(reg_rdata), 2);
    chk(npush == 2, "R11", "words before abort", 64'(npush), 2);
    clr_counts();
    idle(5);
    chk(nvalid == 0, "R11", "no request after abort", 64'(nvalid), 0);
    wr(2'd1, 32'h2);
    chk(reg_rdata === 32'h0, "R10", "Error cleared", 64'(reg_rdata), 0);
    wr(2'd0, 32'h0);
    abort_addr = 32'hFFFF_FFFF;

    // soft reset mid transfer
    rx_lvl = 16; rx_idx = 0;
    wr(2'd2, 32'h500);
    clr_counts();
    wr(2'd0, 32'h9);
    ev_data = 1'b1;
    tick();
    idle(6);
    soft_rst = 1'b1;
    tick();
    chk(reg_rdata === 32'h0 && irq === 1'b0, "R12", "soft reset clears Active", 64'(reg_rdata), 0);
    chk(npop > 0 && npop < 16, "R12", "stopped mid transfer", 64'(npop), 1);
    clr_counts();
    idle(5);
    chk(nvalid == 0, "R12", "no request after soft reset", 64'(nvalid), 0);
    wr(2'd0, 32'h0);
    rx_lvl = 0;

    // zero length means 16384 words
    wr(2'd2, 32'h600);
    clr_counts();
    wr(2'd0, 32'h1);
    ev_activate = 1'b1;
    tick();
    run_to_idle(40000);
    chk(npush == 16384, "R1", "zero length moves 16384 words", 64'(npush), 16384);
    chk(reg_rdata === 32'h4, "R9", "Interrupt after long transfer", 64'(reg_rdata), 4);

    summary();
    $finish;
  end
endmodule